// File: doc/BRIEF.md
# Write-Once Coherent Cache Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Each line holds a single data word together with a tag and one of four coherence states: invalid, valid (clean and possibly shared), reserved (clean and held by this cache only) and dirty (modified and held by this cache only). The processor side uses a request line with a one-cycle ready pulse. The bus side uses a request/grant pair, a command, an address, write data, read data and a completion strobe.

The first store to a clean shared line is written through to memory. Every other copy in the system is invalidated by that write, and the line becomes reserved. Later stores to a reserved or dirty line stay inside the cache and need no bus traffic. While another master owns the bus, the controller watches that master's cycles. A write or write-back that matches a held line invalidates the line. A read that matches a reserved line demotes it to valid. A read that matches a dirty line makes this cache hand over its data on a snoop response one cycle later, and the line becomes valid. The bus arbiter, the memory and the other caches are outside the block.

Top module: `wo_snoop_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `bus_req` are low, and `bus_cmd` is idle. The command encoding is 0 = idle, 1 = read, 2 = write, 3 = write-back.
- R2: A load that misses issues one bus read and installs the line as valid. A later load to the same address hits and issues no bus cycle.
- R3: A store to a line held valid issues one bus write of the store data and leaves the line reserved.
- R4: A store to a line held reserved or dirty updates only the cache, with no bus request, and leaves the line dirty.
- R5: A store miss whose victim is clean issues a single bus write and allocates the line as reserved, so the next store to it stays local.
- R6: A snooped write or write-back whose address matches a held line invalidates that line. The next local load of that address then issues a bus read.
- R7: A snooped read that matches a dirty line raises `snoop_dirty` with the line's data in the following cycle and turns the line valid. The next local store to it is written through.
- R8: A snooped read that matches a reserved line turns it valid, so the next local store to it is written through.
- R9: A miss that lands on a dirty line with a different tag first issues a write-back of the victim's address and data. It then issues the fetch or write of the new address. A dirty line is never overwritten by another tag.
- R10: A bus command is driven only while `bus_grant` is high. The action for a request is chosen from the line state present when the grant arrives.
- R11: `cpu_ready` is a one-cycle pulse. Across caches that share a bus, every load returns the most recently completed store to that address. A snoop that arrives in the same cycle as a local hit takes effect first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership granted |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 write, 3 write-back |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_wdata | output | DATA_W | Data for write and write-back |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_done` |
| bus_done | input | 1 | Completion strobe of the current bus cycle |
| snoop_valid | input | 1 | Another master's cycle is being presented |
| snoop_cmd | input | 2 | Command of the snooped cycle |
| snoop_addr | input | ADDR_W | Address of the snooped cycle |
| snoop_dirty | output | 1 | Snooped read matched a dirty line (one cycle later) |
| snoop_data | output | DATA_W | Data of that dirty line |

## Verification
The bench builds two controllers with an 8-bit address, 16-bit data and only four lines (IDX_W = 2). With so few lines, the random addresses drawn from four tags per index keep colliding. That brings dirty victims, write-backs followed by fetches, and snoops that meet local hits in the same cycle within reach in a few hundred operations. Directed steps walk one line through every state change. The random phase runs both processors concurrently against a reference copy of memory.

// File: rtl/wo_pkg.sv
package wo_pkg;

  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_VALID = 2'd1,
    LS_RSV   = 2'd2,
    LS_DIRTY = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_WRITE = 2'd2,
    BC_WBACK = 2'd3
  } bus_cmd_t;

endpackage

// File: rtl/wo_line_dir.sv
module wo_line_dir
  import wo_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] la_idx,
  output logic [TAG_W-1:0] la_tag,
  output line_st_t         la_st,
  input  logic [IDX_W-1:0] sn_idx,
  output logic [TAG_W-1:0] sn_tag,
  output line_st_t         sn_st,
  input  logic             sn_we,
  input  line_st_t         sn_new,
  input  logic             f_we,
  input  logic [IDX_W-1:0] f_idx,
  input  logic [TAG_W-1:0] f_tag,
  input  line_st_t         f_new
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][TAG_W-1:0] tag_v;
  logic [LINES-1:0][1:0]       st_v;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [TAG_W-1:0] tag_r;
    logic [1:0]       st_r;
    logic             sn_sel;
    logic             f_sel;
    assign sn_sel = sn_we && (sn_idx == IDX_W'(i));
    assign f_sel  = f_we && (f_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        st_r  <= LS_INV;
        tag_r <= '0;
      end else if (sn_sel) begin
        st_r <= sn_new;
      end else if (f_sel) begin
        st_r  <= f_new;
        tag_r <= f_tag;
      end
    end
    assign tag_v[i] = tag_r;
    assign st_v[i]  = st_r;
  end

  assign la_tag = tag_v[la_idx];
  assign la_st  = line_st_t'(st_v[la_idx]);
  assign sn_tag = tag_v[sn_idx];
  assign sn_st  = line_st_t'(st_v[sn_idx]);

  AST_DIRTY_KEPT: assert property (@(posedge clk) disable iff (rst)
    !(f_we && st_v[f_idx] == LS_DIRTY && tag_v[f_idx] != f_tag)); // R9

endmodule

// File: rtl/wo_data_ram.sv
module wo_data_ram #(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];

endmodule

// File: rtl/wo_snoop_cache.sv
module wo_snoop_cache
  import wo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_dirty,
  output logic [DATA_W-1:0] snoop_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {FS_IDLE, FS_ACQ, FS_XFER} fsm_t;
  fsm_t fs;

  logic [IDX_W-1:0]  cpu_idx;
  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  sn_idx;
  logic [TAG_W-1:0]  sn_tag_in;
  logic [TAG_W-1:0]  la_tag, sn_tag;
  line_st_t          la_st, sn_st;
  logic [DATA_W-1:0] la_data, sn_data;

  assign cpu_idx   = cpu_addr[IDX_W-1:0];
  assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
  assign sn_idx    = snoop_addr[IDX_W-1:0];
  assign sn_tag_in = snoop_addr[ADDR_W-1:IDX_W];

  // Snoop side: decide the new state of a matching line
  logic     s_hit, s_hit_dirty, sn_we;
  line_st_t sn_new;

  assign s_hit       = snoop_valid && (sn_st != LS_INV) && (sn_tag == sn_tag_in);
  assign s_hit_dirty = s_hit && (snoop_cmd == BC_READ) && (sn_st == LS_DIRTY);

  always_comb begin
    sn_we  = 1'b0;
    sn_new = sn_st;
    if (s_hit) begin
      if (snoop_cmd == BC_READ) begin
        if (sn_st == LS_DIRTY || sn_st == LS_RSV) begin
          sn_we  = 1'b1;
          sn_new = LS_VALID;
        end
      end else if (snoop_cmd != BC_NONE) begin
        sn_we  = 1'b1;
        sn_new = LS_INV;
      end
    end
  end

  // Processor side: lookup classification
  logic hit, local_ok, victim_dirty, go_local;

  assign hit          = (la_st != LS_INV) && (la_tag == cpu_tag);
  assign local_ok     = hit && (!cpu_we || la_st == LS_RSV || la_st == LS_DIRTY);
  assign victim_dirty = (la_st == LS_DIRTY) && !hit;
  assign go_local     = cpu_req && local_ok &&
                        ((fs == FS_IDLE && !snoop_valid && !cpu_ready) ||
                         (fs == FS_ACQ && bus_grant));

  // Array write port from the controller
  logic              f_we, d_we;
  logic [TAG_W-1:0]  f_tag;
  line_st_t          f_new;
  logic [DATA_W-1:0] d_wdata;

  always_comb begin
    f_we    = 1'b0;
    f_tag   = cpu_tag;
    f_new   = la_st;
    d_we    = 1'b0;
    d_wdata = cpu_wdata;
    if (go_local && cpu_we) begin
      f_we  = 1'b1;
      f_new = LS_DIRTY;
      d_we  = 1'b1;
    end else if (fs == FS_XFER && bus_done) begin
      unique case (bus_cmd)
        BC_WBACK: begin
          f_we  = 1'b1;
          f_tag = la_tag;
          f_new = LS_INV;
        end
        BC_READ: begin
          f_we    = 1'b1;
          f_new   = LS_VALID;
          d_we    = 1'b1;
          d_wdata = bus_rdata;
        end
        BC_WRITE: begin
          f_we  = 1'b1;
          f_new = LS_RSV;
          d_we  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  wo_line_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dir (
    .clk    (clk),
    .rst    (rst),
    .la_idx (cpu_idx),
    .la_tag (la_tag),
    .la_st  (la_st),
    .sn_idx (sn_idx),
    .sn_tag (sn_tag),
    .sn_st  (sn_st),
    .sn_we  (sn_we),
    .sn_new (sn_new),
    .f_we   (f_we),
    .f_idx  (cpu_idx),
    .f_tag  (f_tag),
    .f_new  (f_new)
  );

  wo_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .we      (d_we),
    .widx    (cpu_idx),
    .wdata   (d_wdata),
    .ra_idx  (cpu_idx),
    .ra_data (la_data),
    .rb_idx  (sn_idx),
    .rb_data (sn_data)
  );

  // Registered outputs and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      fs          <= FS_IDLE;
      cpu_ready   <= 1'b0;
      cpu_rdata   <= '0;
      bus_req     <= 1'b0;
      bus_cmd     <= BC_NONE;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      snoop_dirty <= 1'b0;
      snoop_data  <= '0;
    end else begin
      cpu_ready   <= 1'b0;
      snoop_dirty <= s_hit_dirty;
      if (s_hit_dirty) snoop_data <= sn_data;
      unique case (fs)
        FS_IDLE: begin
          if (cpu_req && !cpu_ready && !snoop_valid) begin
            if (local_ok) begin
              cpu_ready <= 1'b1;
              cpu_rdata <= cpu_we ? cpu_wdata : la_data;
            end else begin
              bus_req <= 1'b1;
              fs      <= FS_ACQ;
            end
          end
        end
        FS_ACQ: begin
          if (bus_grant) begin
            if (local_ok) begin
              cpu_ready <= 1'b1;
              cpu_rdata <= cpu_we ? cpu_wdata : la_data;
              bus_req   <= 1'b0;
              fs        <= FS_IDLE;
            end else if (victim_dirty) begin
              bus_cmd   <= BC_WBACK;
              bus_addr  <= {la_tag, cpu_idx};
              bus_wdata <= la_data;
              fs        <= FS_XFER;
            end else if (!cpu_we) begin
              bus_cmd  <= BC_READ;
              bus_addr <= cpu_addr;
              fs       <= FS_XFER;
            end else begin
              bus_cmd   <= BC_WRITE;
              bus_addr  <= cpu_addr;
              bus_wdata <= cpu_wdata;
              fs        <= FS_XFER;
            end
          end
        end
        FS_XFER: begin
          if (bus_done) begin
            bus_cmd <= BC_NONE;
            if (bus_cmd == BC_WBACK) begin
              fs <= FS_ACQ;
            end else begin
              cpu_ready <= 1'b1;
              cpu_rdata <= (bus_cmd == BC_READ) ? bus_rdata : cpu_wdata;
              bus_req   <= 1'b0;
              fs        <= FS_IDLE;
            end
          end
        end
        default: fs <= FS_IDLE;
      endcase
    end
  end

  AST_CMD_UNDER_GRANT: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != BC_NONE) |-> bus_grant); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R11

  AST_DIRTY_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && snoop_cmd == BC_READ && sn_st == LS_DIRTY && sn_tag == sn_tag_in)
      |=> snoop_dirty); // R7

  AST_LOCAL_STORE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fs == FS_IDLE && cpu_req && cpu_we && !cpu_ready && !snoop_valid && hit &&
     la_st == LS_DIRTY) |=> !bus_req); // R4

  AST_WT_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (fs == FS_XFER && bus_done && bus_cmd == BC_WRITE)
      |=> (!$stable(cpu_addr) || la_st == LS_RSV)); // R3

endmodule

// File: tb/tb_wo_snoop_cache.sv
module tb_wo_snoop_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam logic [1:0] C_RD = 2'd1;
  localparam logic [1:0] C_WR = 2'd2;
  localparam logic [1:0] C_WB = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          c_req   [2];
  logic          c_we    [2];
  logic [AW-1:0] c_addr  [2];
  logic [DW-1:0] c_wdata [2];
  logic [DW-1:0] c_rdata [2];
  logic          c_ready [2];
  logic          b_req   [2];
  logic          b_gnt   [2];
  logic [1:0]    b_cmd   [2];
  logic [AW-1:0] b_addr  [2];
  logic [DW-1:0] b_wdata [2];
  logic [DW-1:0] b_rdata [2];
  logic          b_done  [2];
  logic          s_valid [2];
  logic [1:0]    s_cmd   [2];
  logic [AW-1:0] s_addr  [2];
  logic          s_dirty [2];
  logic [DW-1:0] s_data  [2];

  wo_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut (
    .clk(clk), .rst(rst),
    .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]), .cpu_wdata(c_wdata[0]),
    .cpu_rdata(c_rdata[0]), .cpu_ready(c_ready[0]),
    .bus_req(b_req[0]), .bus_grant(b_gnt[0]), .bus_cmd(b_cmd[0]), .bus_addr(b_addr[0]),
    .bus_wdata(b_wdata[0]), .bus_rdata(b_rdata[0]), .bus_done(b_done[0]),
    .snoop_valid(s_valid[0]), .snoop_cmd(s_cmd[0]), .snoop_addr(s_addr[0]),
    .snoop_dirty(s_dirty[0]), .snoop_data(s_data[0]));

  wo_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut_peer (
    .clk(clk), .rst(rst),
    .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]), .cpu_wdata(c_wdata[1]),
    .cpu_rdata(c_rdata[1]), .cpu_ready(c_ready[1]),
    .bus_req(b_req[1]), .bus_grant(b_gnt[1]), .bus_cmd(b_cmd[1]), .bus_addr(b_addr[1]),
    .bus_wdata(b_wdata[1]), .bus_rdata(b_rdata[1]), .bus_done(b_done[1]),
    .snoop_valid(s_valid[1]), .snoop_cmd(s_cmd[1]), .snoop_addr(s_addr[1]),
    .snoop_dirty(s_dirty[1]), .snoop_data(s_data[1]));

  logic [DW-1:0] mem  [256];
  logic [DW-1:0] refm [256];
  int cnt [2][4];
  logic [1:0]    last_cmd [2];
  logic [1:0]    prev_cmd [2];
  logic [AW-1:0] last_a   [2];
  logic [AW-1:0] prev_a   [2];
  int nchk = 0;
  int nerr = 0;
  int gnt_viol = 0;

  function automatic logic [DW-1:0] minit(input int a);
    return DW'((a * 257) ^ 16'h5a3c);
  endfunction

  function automatic int nbus(input int id);
    return cnt[id][1] + cnt[id][2] + cnt[id][3];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_op(input int id, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] r);
    @(negedge clk);
    c_req[id] = 1'b1; c_we[id] = we; c_addr[id] = a; c_wdata[id] = d;
    do @(negedge clk); while (!c_ready[id]);
    r = c_rdata[id];
    c_req[id] = 1'b0;
    if (we) refm[a] = d;
    else chk(r == refm[a], "R11", "load returns latest store", int'(r), int'(refm[a]));
  endtask

  // Arbiter, memory and snoop broadcaster
  initial begin
    int owner;
    int first;
    int o;
    int p;
    logic [1:0]    cmd;
    logic [AW-1:0] a;
    logic [DW-1:0] w;
    owner = -1;
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (owner < 0) begin
        first = int'($urandom % 2);
        for (int k = 0; k < 2; k++) begin
          if (owner < 0 && b_req[(first + k) % 2]) begin
            owner = (first + k) % 2;
            b_gnt[owner] = 1'b1;
          end
        end
      end else if (!b_req[owner]) begin
        b_gnt[owner] = 1'b0;
        owner = -1;
      end else if (b_cmd[owner] != 2'd0) begin
        o = owner; p = 1 - owner;
        cmd = b_cmd[o]; a = b_addr[o]; w = b_wdata[o];
        cnt[o][cmd] = cnt[o][cmd] + 1;
        prev_cmd[o] = last_cmd[o]; prev_a[o] = last_a[o];
        last_cmd[o] = cmd; last_a[o] = a;
        s_valid[p] = 1'b1; s_cmd[p] = cmd; s_addr[p] = a;
        @(negedge clk);
        s_valid[p] = 1'b0;
        if (s_dirty[p]) mem[a] = s_data[p];
        if (cmd == C_RD) b_rdata[o] = mem[a];
        else mem[a] = w;
        b_done[o] = 1'b1;
        @(negedge clk);
        b_done[o] = 1'b0;
      end
    end
  end

  // Command-without-grant monitor (R10)
  initial begin
    forever begin
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        if (!rst && b_cmd[i] != 2'd0 && !b_gnt[i]) gnt_viol++;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R11 watchdog: actual=hung expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    int s;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i] = minit(i);
      refm[i] = minit(i);
    end
    for (int i = 0; i < 2; i++) begin
      c_req[i] = 0; c_we[i] = 0; c_addr[i] = 0; c_wdata[i] = 0;
      b_gnt[i] = 0; b_rdata[i] = 0; b_done[i] = 0;
      s_valid[i] = 0; s_cmd[i] = 0; s_addr[i] = 0;
      last_cmd[i] = 0; prev_cmd[i] = 0; last_a[i] = 0; prev_a[i] = 0;
      for (int j = 0; j < 4; j++) cnt[i][j] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state at the ports
    for (int i = 0; i < 2; i++) begin
      chk(c_ready[i] == 1'b0, "R1", "cpu_ready after reset", int'(c_ready[i]), 0);
      chk(b_req[i] == 1'b0, "R1", "bus_req after reset", int'(b_req[i]), 0);
      chk(b_cmd[i] == 2'd0, "R1", "bus_cmd after reset", int'(b_cmd[i]), 0);
    end

    // R2: load miss then load hit
    s = cnt[0][1];
    cpu_op(0, 0, 8'h10, 0, r);
    chk(r == minit(8'h10), "R2", "fill value", int'(r), int'(minit(8'h10)));
    chk(cnt[0][1] == s + 1, "R2", "one bus read on miss", cnt[0][1], s + 1);
    s = nbus(0);
    cpu_op(0, 0, 8'h10, 0, r);
    chk(nbus(0) == s, "R2", "no bus cycle on load hit", nbus(0), s);

    // R3: first store to a valid line writes through
    s = cnt[0][2];
    cpu_op(0, 1, 8'h10, 16'h1111, r);
    chk(cnt[0][2] == s + 1, "R3", "write-through issued", cnt[0][2], s + 1);
    chk(mem[8'h10] == 16'h1111, "R3", "memory updated", int'(mem[8'h10]), 16'h1111);

    // R4: store to reserved line stays local
    s = nbus(0);
    cpu_op(0, 1, 8'h10, 16'h2222, r);
    chk(nbus(0) == s, "R4", "no bus cycle on reserved store", nbus(0), s);
    chk(mem[8'h10] == 16'h1111, "R4", "memory untouched", int'(mem[8'h10]), 16'h1111);

    // R7: peer read of dirty line gets flushed data
    cpu_op(1, 0, 8'h10, 0, r);
    chk(r == 16'h2222, "R7", "peer load sees dirty data", int'(r), 16'h2222);
    chk(mem[8'h10] == 16'h2222, "R7", "memory updated by flush", int'(mem[8'h10]), 16'h2222);
    s = cnt[0][2];
    cpu_op(0, 1, 8'h10, 16'h3333, r);
    chk(cnt[0][2] == s + 1, "R7", "line valid after flush, store writes through", cnt[0][2], s + 1);

    // R6: peer copy invalidated by that write
    s = cnt[1][1];
    cpu_op(1, 0, 8'h10, 0, r);
    chk(cnt[1][1] == s + 1, "R6", "invalidated line misses", cnt[1][1], s + 1);
    chk(r == 16'h3333, "R6", "refetched value", int'(r), 16'h3333);

    // R8: reserved line demoted to valid by peer read
    s = cnt[0][2];
    cpu_op(0, 1, 8'h10, 16'h4444, r);
    chk(cnt[0][2] == s + 1, "R8", "store after peer read writes through", cnt[0][2], s + 1);

    // R5: store miss with clean victim allocates reserved
    s = cnt[0][3];
    cpu_op(0, 1, 8'h20, 16'h5555, r);
    chk(cnt[0][3] == s, "R5", "no write-back of clean victim", cnt[0][3], s);
    chk(last_cmd[0] == C_WR && last_a[0] == 8'h20, "R5", "write of allocated address",
        int'(last_a[0]), 8'h20);
    s = nbus(0);
    cpu_op(0, 1, 8'h20, 16'h6666, r);
    chk(nbus(0) == s, "R5", "second store local", nbus(0), s);

    // R9: dirty victim written back before fetch
    cpu_op(0, 0, 8'h30, 0, r);
    chk(prev_cmd[0] == C_WB && prev_a[0] == 8'h20, "R9", "write-back of victim first",
        int'({prev_cmd[0], prev_a[0]}), int'({C_WB, 8'h20}));
    chk(last_cmd[0] == C_RD && last_a[0] == 8'h30, "R9", "then fetch of new line",
        int'({last_cmd[0], last_a[0]}), int'({C_RD, 8'h30}));
    chk(mem[8'h20] == 16'h6666, "R9", "victim data in memory", int'(mem[8'h20]), 16'h6666);

    // R11: concurrent random traffic on colliding addresses
    fork
      begin
        logic [DW-1:0] r0;
        for (int n = 0; n < 400; n++)
          cpu_op(0, bit'($urandom % 2), AW'((($urandom % 4) << 4) | ($urandom % 4)),
                 DW'($urandom), r0);
      end
      begin
        logic [DW-1:0] r1;
        for (int n = 0; n < 400; n++)
          cpu_op(1, bit'($urandom % 2), AW'((($urandom % 4) << 4) | ($urandom % 4)),
                 DW'($urandom), r1);
      end
    join

    chk(gnt_viol == 0, "R10", "commands only under grant", gnt_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule